// File: doc/BRIEF.md
# Coefficient-Programmed Threshold Logic Cell

This block is a one-bit, two-input logic element whose function is set by integer coefficients, not by a fixed gate. Inside is a small feed-forward network. Two hidden neurons each add a bias to the operand-gated weights and fire when the total is zero or more. One output neuron combines the two hidden firings in the same way. With suitable coefficients the network reproduces any of the seven common two-input functions, including the two exclusive forms that a single neuron cannot separate.

Nine signed coefficients sit in a small register bank. Software or a controller fills them one slot at a time through a write port. A single pulse can also replace all nine with one of seven built-in sets chosen by an opcode. The result is registered, so it follows the operands with one clock of latency. Replicating the cell per bit gives a bitwise logic unit whose operation changes by reloading coefficients.

Top module: `percep_logic_cell`

## Requirements
- R1: When the synchronous active-high reset `rst` is high at a clock edge, all nine coefficients become 0 and `result` becomes 0.
- R2: Each neuron fires (1) exactly when bias plus the weights of its active inputs is greater than or equal to zero, evaluated in 5-bit two's complement. A total of exactly 0 fires and -1 does not. With every coefficient zero, `result` is 1.
- R3: When `coef_we` is high at a clock edge, `coef_wdata` is stored in slot `coef_idx`. Slot map: 0 and 1 are hidden neuron 0's weights on `op_a` and `op_b`; 2 and 3 are hidden neuron 1's weights on `op_a` and `op_b`; 4 and 5 are the output neuron's weights on hidden 0 and hidden 1; 6, 7 and 8 are the biases of hidden 0, hidden 1 and the output. Writes to indices 9 to 15 change nothing.
- R4: `result` is registered. It takes the function of the operands present at an edge, using the coefficients held before that edge. A coefficient change at an edge first affects the result at the following edge.
- R5: `preset_load` high at an edge replaces all nine coefficients with a built-in set. The `preset_op` codes are 0 AND, 1 OR, 2 NAND, 3 NOR, 4 NOT of `op_a`, 5 XOR and 6 XNOR. After the load, `result` equals that function of the operands.
- R6: `preset_load` with `preset_op` = 7 leaves all coefficients unchanged.
- R7: If `preset_load` and `coef_we` are high at the same edge, the preset set is loaded and the addressed slot then takes `coef_wdata`.
- R8: Sums at the coefficient extremes do not wrap. All nine slots at +3 with both operands 1 give `result` 1. All nine at -4 give `result` 0 for both operands 0 and both operands 1.
- R9: Under the NOT preset, `result` does not depend on `op_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| coef_we | input | 1 | Write one coefficient slot |
| coef_idx | input | 4 | Slot index for the write |
| coef_wdata | input | 3 | Signed coefficient value to write |
| preset_load | input | 1 | Load a built-in coefficient set |
| preset_op | input | 3 | Built-in set selector (7 = keep current) |
| op_a | input | 1 | First operand |
| op_b | input | 1 | Second operand |
| result | output | 1 | Registered cell output |

## Verification
A preset load and a single-slot write can land at the same edge. This is provoked by loading the AND set while writing 0 into the output-bias slot. With the write taking effect the output neuron always fires, so the result reads 1 even for operands 0,0. If the write were lost the plain AND would read 0. Evaluation and reconfiguration can also coincide. This is judged by switching from AND to NAND with both operands at 1: the result must show the old function for one edge and the new one on the next.

// File: rtl/pcell_pkg.sv
package pcell_pkg;

  localparam int NUM_SLOTS = 9;

  // Slot positions; the neuron wiring in the top depends on them.
  localparam int SLOT_H0_A  = 0;
  localparam int SLOT_H0_B  = 1;
  localparam int SLOT_H1_A  = 2;
  localparam int SLOT_H1_B  = 3;
  localparam int SLOT_O_H0  = 4;
  localparam int SLOT_O_H1  = 5;
  localparam int SLOT_B_H0  = 6;
  localparam int SLOT_B_H1  = 7;
  localparam int SLOT_B_OUT = 8;

  typedef enum logic [2:0] {
    FN_AND  = 3'd0,
    FN_OR   = 3'd1,
    FN_NAND = 3'd2,
    FN_NOR  = 3'd3,
    FN_NOT  = 3'd4,
    FN_XOR  = 3'd5,
    FN_XNOR = 3'd6,
    FN_KEEP = 3'd7
  } fn_sel_e;

  // Built-in coefficient value for one slot of one function.
  function automatic int preset_val(input logic [2:0] fn, input int slot);
    int t [NUM_SLOTS];
    case (fn_sel_e'(fn))
      FN_AND:  t = '{1, 1, 0, 0,  1,  0, -2,  0, -1};
      FN_OR:   t = '{1, 1, 0, 0,  1,  0, -1,  0, -1};
      FN_NAND: t = '{1, 1, 0, 0, -1,  0, -2,  0,  0};
      FN_NOR:  t = '{1, 1, 0, 0, -1,  0, -1,  0,  0};
      FN_NOT:  t = '{1, 0, 0, 0, -1,  0, -1,  0,  0};
      FN_XOR:  t = '{1, 1, 1, 1,  1, -1, -1, -2, -1};
      FN_XNOR: t = '{1, 1, 1, 1, -1,  1, -1, -2,  0};
      default: t = '{0, 0, 0, 0,  0,  0,  0,  0,  0};
    endcase
    return t[slot];
  endfunction

endpackage

// File: rtl/pcell_coef_bank.sv
module pcell_coef_bank
  import pcell_pkg::*;
#(
  parameter int COEF_W = 3,
  parameter int IDX_W  = 4,
  parameter int NSLOT  = NUM_SLOTS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [COEF_W-1:0]       wr_data,
  input  logic                    ld_en,
  input  logic [2:0]              ld_fn,
  output logic [NSLOT*COEF_W-1:0] coefs
);

  logic ld_take;
  assign ld_take = ld_en && (ld_fn != FN_KEEP);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [COEF_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else begin
        if (ld_take)
          q <= COEF_W'(preset_val(ld_fn, s));
        // a same-edge slot write overrides the preset value
        if (wr_en && (wr_idx == IDX_W'(s)))
          q <= wr_data;
      end
    end
    assign coefs[s*COEF_W +: COEF_W] = q;
  end

endmodule

// File: rtl/pcell_neuron.sv
module pcell_neuron #(
  parameter int COEF_W = 3,
  parameter int SUM_W  = COEF_W + 2
) (
  input  logic              in0,
  input  logic              in1,
  input  logic [COEF_W-1:0] w0,
  input  logic [COEF_W-1:0] w1,
  input  logic [COEF_W-1:0] bias,
  output logic              fire
);

  localparam int EXT_W = SUM_W - COEF_W;
  localparam logic signed [SUM_W-1:0] ZERO = '0;

  logic signed [SUM_W-1:0] bias_x, w0_x, w1_x, net;

  always_comb begin
    bias_x = {{EXT_W{bias[COEF_W-1]}}, bias};
    w0_x   = in0 ? {{EXT_W{w0[COEF_W-1]}}, w0} : ZERO;
    w1_x   = in1 ? {{EXT_W{w1[COEF_W-1]}}, w1} : ZERO;
    net    = bias_x + w0_x + w1_x;
    // signed compare with zero reduces to the inverted sign bit
    fire   = (net >= ZERO);
  end

endmodule

// File: rtl/percep_logic_cell.sv
module percep_logic_cell
  import pcell_pkg::*;
#(
  parameter int COEF_W = 3,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              coef_we,
  input  logic [IDX_W-1:0]  coef_idx,
  input  logic [COEF_W-1:0] coef_wdata,
  input  logic              preset_load,
  input  logic [2:0]        preset_op,
  input  logic              op_a,
  input  logic              op_b,
  output logic              result
);

  localparam int NSLOT   = NUM_SLOTS;
  localparam int SUM_W   = COEF_W + 2;
  localparam int NHIDDEN = 2;

  logic [NSLOT*COEF_W-1:0] coef_flat;
  logic [NHIDDEN-1:0]      hid;
  logic                    out_fire;
  logic                    result_q;

  pcell_coef_bank #(
    .COEF_W(COEF_W), .IDX_W(IDX_W), .NSLOT(NSLOT)
  ) i_bank (
    .clk(clk), .rst(rst),
    .wr_en(coef_we), .wr_idx(coef_idx), .wr_data(coef_wdata),
    .ld_en(preset_load), .ld_fn(preset_op),
    .coefs(coef_flat)
  );

  for (genvar h = 0; h < NHIDDEN; h++) begin : g_hidden
    localparam int SA = (h == 0) ? SLOT_H0_A : SLOT_H1_A;
    localparam int SB = (h == 0) ? SLOT_H0_B : SLOT_H1_B;
    localparam int SC = (h == 0) ? SLOT_B_H0 : SLOT_B_H1;
    pcell_neuron #(.COEF_W(COEF_W), .SUM_W(SUM_W)) i_neuron (
      .in0(op_a), .in1(op_b),
      .w0(coef_flat[SA*COEF_W +: COEF_W]),
      .w1(coef_flat[SB*COEF_W +: COEF_W]),
      .bias(coef_flat[SC*COEF_W +: COEF_W]),
      .fire(hid[h])
    );
  end

  pcell_neuron #(.COEF_W(COEF_W), .SUM_W(SUM_W)) i_out_neuron (
    .in0(hid[0]), .in1(hid[1]),
    .w0(coef_flat[SLOT_O_H0*COEF_W +: COEF_W]),
    .w1(coef_flat[SLOT_O_H1*COEF_W +: COEF_W]),
    .bias(coef_flat[SLOT_B_OUT*COEF_W +: COEF_W]),
    .fire(out_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) result_q <= 1'b0;
    else     result_q <= out_fire;
  end

  assign result = result_q;

endmodule

// File: rtl/pcell_checker.sv
module pcell_checker #(
  parameter int COEF_W = 3,
  parameter int IDX_W  = 4,
  parameter int NSLOT  = 9
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    coef_we,
  input logic [IDX_W-1:0]        coef_idx,
  input logic [COEF_W-1:0]       coef_wdata,
  input logic                    preset_load,
  input logic [2:0]              preset_op,
  input logic                    op_a,
  input logic                    op_b,
  input logic                    result,
  input logic [NSLOT*COEF_W-1:0] coef_flat
);

  logic [IDX_W-1:0]  idx_q;
  logic [COEF_W-1:0] data_q;
  always_ff @(posedge clk) begin
    idx_q  <= coef_idx;
    data_q <= coef_wdata;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (result == 1'b0 && coef_flat == '0));

  assert_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
    (coef_we && coef_idx < IDX_W'(NSLOT))
      |=> (coef_flat[idx_q*COEF_W +: COEF_W] == data_q));

  assert_bad_idx_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (coef_we && coef_idx >= IDX_W'(NSLOT) && !preset_load) |=> $stable(coef_flat));

  assert_keep_code_R6: assert property (@(posedge clk) disable iff (rst)
    (preset_load && preset_op == 3'd7 && !coef_we) |=> $stable(coef_flat));

  assert_and_preset_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(preset_load, 2) && $past(preset_op, 2) == 3'd0 && !$past(coef_we, 2)
     && !$past(rst, 2) && !$past(rst) && !$past(coef_we) && !$past(preset_load))
      |-> (result == ($past(op_a) & $past(op_b))));

  assert_xor_preset_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(preset_load, 2) && $past(preset_op, 2) == 3'd5 && !$past(coef_we, 2)
     && !$past(rst, 2) && !$past(rst) && !$past(coef_we) && !$past(preset_load))
      |-> (result == ($past(op_a) ^ $past(op_b))));

endmodule

bind percep_logic_cell pcell_checker #(
  .COEF_W(COEF_W), .IDX_W(IDX_W), .NSLOT(NSLOT)
) i_pcell_checker (
  .clk(clk), .rst(rst), .coef_we(coef_we), .coef_idx(coef_idx),
  .coef_wdata(coef_wdata), .preset_load(preset_load), .preset_op(preset_op),
  .op_a(op_a), .op_b(op_b), .result(result), .coef_flat(coef_flat)
);

// File: tb/test_percep_logic_cell.sv
module test_percep_logic_cell;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       coef_we = 1'b0;
  logic [3:0] coef_idx = '0;
  logic [2:0] coef_wdata = '0;
  logic       preset_load = 1'b0;
  logic [2:0] preset_op = '0;
  logic       op_a = 1'b0;
  logic       op_b = 1'b0;
  logic       result;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  percep_logic_cell i_percep_logic_cell (
    .clk(clk), .rst(rst), .coef_we(coef_we), .coef_idx(coef_idx),
    .coef_wdata(coef_wdata), .preset_load(preset_load), .preset_op(preset_op),
    .op_a(op_a), .op_b(op_b), .result(result)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: result=%b expected=%b", req, got, exp);
    end
  endtask

  function automatic logic ref_fn(input int fn, input logic a, input logic b);
    case (fn)
      0: return a & b;
      1: return a | b;
      2: return ~(a & b);
      3: return ~(a | b);
      4: return ~a;
      5: return a ^ b;
      default: return ~(a ^ b);
    endcase
  endfunction

  task automatic eval(input logic a, input logic b);
    op_a = a; op_b = b;
    tick();
  endtask

  task automatic wr(input int idx, input int val);
    coef_we = 1'b1; coef_idx = 4'(idx); coef_wdata = 3'(val);
    tick();
    coef_we = 1'b0;
  endtask

  task automatic load(input int fn);
    preset_load = 1'b1; preset_op = 3'(fn);
    tick();
    preset_load = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick();
    rst = 1'b0;
  endtask

  // R1 reset state, R2 all-zero coefficients fire
  task automatic t_reset();
    rst = 1'b1; op_a = 1'b1; op_b = 1'b1;
    tick(); tick();
    chk("R1 reset result", result, 1'b0);
    rst = 1'b0;
    eval(1'b0, 1'b0);
    chk("R2 zero coefs 00", result, 1'b1);
    eval(1'b1, 1'b1);
    chk("R2 zero coefs 11", result, 1'b1);
  endtask

  // R3 slot map, R2 zero/-1 boundary
  task automatic t_write_map();
    do_reset();
    wr(8, -1);
    eval(1'b1, 1'b0);
    chk("R2 output sum -1", result, 1'b0);
    wr(5, 1);
    eval(1'b0, 1'b0);
    chk("R2 output sum 0", result, 1'b1);
    wr(7, -1);
    eval(1'b0, 1'b1);
    chk("R3 hidden1 bias slot", result, 1'b0);
    wr(3, 1);
    eval(1'b1, 1'b0);
    chk("R3 hidden1 op_b slot b=0", result, 1'b0);
    eval(1'b0, 1'b1);
    chk("R3 hidden1 op_b slot b=1", result, 1'b1);
    wr(12, -4);
    eval(1'b0, 1'b1);
    chk("R3 idx 12 ignored b=1", result, 1'b1);
    eval(1'b1, 1'b0);
    chk("R3 idx 12 ignored b=0", result, 1'b0);
  endtask

  // R5 every preset, all operand pairs
  task automatic t_presets();
    for (int fn = 0; fn < 7; fn++) begin
      load(fn);
      for (int p = 0; p < 4; p++) begin
        eval(p[1], p[0]);
        chk($sformatf("R5 fn %0d pair %0d", fn, p), result, ref_fn(fn, p[1], p[0]));
      end
    end
  endtask

  // R9 NOT ignores op_b
  task automatic t_not_b();
    load(4);
    eval(1'b0, 1'b1);
    chk("R9 not a=0 b=1", result, 1'b1);
    eval(1'b1, 1'b1);
    chk("R9 not a=1 b=1", result, 1'b0);
    eval(1'b1, 1'b0);
    chk("R9 not a=1 b=0", result, 1'b0);
  endtask

  // R4 old function at the reload edge, new one after
  task automatic t_timing();
    load(0);
    op_a = 1'b1; op_b = 1'b1;
    preset_load = 1'b1; preset_op = 3'd2;
    tick();
    preset_load = 1'b0;
    chk("R4 old coefs at reload edge", result, 1'b1);
    tick();
    chk("R4 new coefs next edge", result, 1'b0);
  endtask

  // R6 keep code
  task automatic t_keep();
    load(5);
    load(7);
    for (int p = 0; p < 4; p++) begin
      eval(p[1], p[0]);
      chk($sformatf("R6 keep xor pair %0d", p), result, p[1] ^ p[0]);
    end
  endtask

  // R7 preset and write together
  task automatic t_same_edge();
    preset_load = 1'b1; preset_op = 3'd0;
    coef_we = 1'b1; coef_idx = 4'd8; coef_wdata = 3'd0;
    tick();
    preset_load = 1'b0; coef_we = 1'b0;
    eval(1'b0, 1'b0);
    chk("R7 write over preset 00", result, 1'b1);
    eval(1'b1, 1'b0);
    chk("R7 write over preset 10", result, 1'b1);
  endtask

  // R8 extreme sums
  task automatic t_extremes();
    do_reset();
    for (int s = 0; s < 9; s++) wr(s, 3);
    eval(1'b1, 1'b1);
    chk("R8 all +3", result, 1'b1);
    for (int s = 0; s < 9; s++) wr(s, -4);
    eval(1'b1, 1'b1);
    chk("R8 all -4 ops 11", result, 1'b0);
    eval(1'b0, 1'b0);
    chk("R8 all -4 ops 00", result, 1'b0);
  endtask

  initial begin
    t_reset();
    t_write_map();
    t_presets();
    t_not_b();
    t_timing();
    t_keep();
    t_same_edge();
    t_extremes();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: result=%b expected=finished", result);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule